// File: doc/BRIEF.md
# Frame Decimation and Capture Gate

This block sits in a camera capture path between the sensor-side pixel stream (frame-valid, line-valid, pixel data) and the upload FIFO. For every incoming frame it decides once, at the rising edge of frame-valid, whether the entire frame is passed on or discarded. The aim is to keep the forwarded bandwidth below the limit of the upstream link.

An 8-bit ratio code selects how many frames are kept. The upper nibble is the keep count K and the lower nibble is the window length W. In each window of W frames, the first K frames are kept. A few codes have special meanings: codes that mean "keep everything", and a legacy "every other frame" code.

A hold mode stops frames from entering the window. While hold is set, the host can fire a one-frame capture. When the captured frame ends, a sticky completion flag is raised and stays up until the host clears it. A separate mute control blanks the output cycle by cycle while the frame counting continues.

Top module: `frame_gate`

## Requirements
- R1: After reset, `fv_out`, `lv_out`, `pix_out` and `shot_done` are all 0.
- R2: A kept frame appears at the outputs one clock after the inputs. `lv_out` is high only when the input line-valid and frame-valid were both high. `pix_out` is 0 whenever `lv_out` is 0.
- R3: All frames are kept for these ratio codes: 0x00, 0x11, any code whose lower nibble is 0, and any code whose upper nibble K is greater than or equal to its nonzero lower nibble W.
- R4: Code 0x01 keeps alternate frames. The first frame after the code takes effect is kept.
- R5: For 1 <= K < W, within each window of W counted frames, frames 0 to K-1 are kept and the rest are dropped. The pattern repeats every W frames (for example, 0x23 gives keep, keep, drop; 0x1F keeps one frame in 15).
- R6: A code with K = 0 and W >= 2 drops every frame.
- R7: A new ratio code takes effect at the next frame start and restarts the window at position 0. A change in the middle of a frame does not alter the current frame.
- R8: The keep/drop decision is made only at the rising edge of `fv_in`. A frame is either passed whole or dropped whole.
- R9: While `hold_en` is 1, frames are dropped and the window position does not advance. After hold is released, counting resumes from the position it had before the hold.
- R10: A rising edge on `shot_req` while `hold_en` is 1 arms a capture. The next frame start passes exactly that one frame. A `shot_req` edge while hold is 0 is ignored, and dropping hold disarms a pending capture.
- R11: `shot_done` rises one clock after the captured frame's frame-valid falls. It stays 1 until a rising edge of `done_clr`.
- R12: While `mute` is 1, the outputs are forced low one clock later. The window still advances for every frame that starts during mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fv_in | input | 1 | Frame-valid from the sensor |
| lv_in | input | 1 | Line-valid from the sensor |
| pix_in | input | PIX_W | Pixel data from the sensor |
| ratio_code | input | 8 | Keep count K in bits 7:4, window length W in bits 3:0 |
| hold_en | input | 1 | Hold mode: stop admitting frames |
| shot_req | input | 1 | One-frame capture request, acted on at its rising edge |
| done_clr | input | 1 | Clears `shot_done` at its rising edge |
| mute | input | 1 | Blanks the outputs without stopping frame counting |
| fv_out | output | 1 | Gated frame-valid |
| lv_out | output | 1 | Gated line-valid |
| pix_out | output | PIX_W | Gated pixel data |
| shot_done | output | 1 | Sticky completion flag for the one-frame capture |

## Verification
A wrong window position cannot be seen inside a frame. It only shows up at the next frame start, as a whole frame kept or dropped out of turn. For that reason the bench compares every cycle of every frame against a per-frame prediction, and it runs long sequences under each code so that an off-by-one wrap appears within one window length. A stuck capture arm, or a capture flag that clears itself, shows up within one frame as an extra forwarded frame or as `shot_done` falling without a clear edge. A mute that disturbs the counting is seen in the frame that follows the mute.

// File: rtl/frame_gate_pkg.sv
package frame_gate_pkg;

  typedef struct packed {
    logic       pass_all;
    logic [3:0] keep;
    logic [3:0] span;
  } ratio_t;

  // Decode the 8-bit ratio code into an effective keep/span pair.
  function automatic ratio_t decode_ratio(input logic [7:0] code);
    ratio_t r;
    r.keep     = code[7:4];
    r.span     = code[3:0];
    r.pass_all = 1'b0;
    if (code == 8'h00) begin
      r.pass_all = 1'b1;
    end else if (code == 8'h01) begin
      r.keep = 4'd1;
      r.span = 4'd2;
    end else if (code[3:0] == 4'd0 || code[7:4] >= code[3:0]) begin
      r.pass_all = 1'b1;
    end
    return r;
  endfunction

  // Is position pos inside the kept part of the window?
  function automatic logic slot_kept(input ratio_t r, input logic [3:0] pos);
    return r.pass_all || (pos < r.keep);
  endfunction

  // Position after pos, wrapping at the window span.
  function automatic logic [3:0] slot_next(input ratio_t r, input logic [3:0] pos);
    logic [4:0] inc;
    inc = {1'b0, pos} + 5'd1;
    if (r.pass_all || inc >= {1'b0, r.span}) return 4'd0;
    return inc[3:0];
  endfunction

endpackage

// File: rtl/fg_edge.sv
module fg_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic evt
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  generate
    if (RISING) begin : g_rise
      assign evt = sig & ~sig_q;
    end else begin : g_fall
      assign evt = ~sig & sig_q;
    end
  endgenerate
endmodule

// File: rtl/fg_ratio_sched.sv
module fg_ratio_sched
  import frame_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       count_start,
  input  logic [7:0] ratio_code,
  output logic       keep_now
);
  logic [7:0] code_q;
  logic [3:0] pos_q;
  logic       code_changed;
  logic [3:0] pos_eff;
  ratio_t     rdec;

  always_comb begin
    rdec         = decode_ratio(ratio_code);
    code_changed = (ratio_code != code_q);
    pos_eff      = code_changed ? 4'd0 : pos_q;
    keep_now     = slot_kept(rdec, pos_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 8'h00;
      pos_q  <= 4'd0;
    end else if (count_start) begin
      code_q <= ratio_code;
      pos_q  <= slot_next(rdec, pos_eff);
    end
  end
endmodule

// File: rtl/fg_shot_ctrl.sv
module fg_shot_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_en,
  input  logic shot_req,
  input  logic done_clr,
  input  logic frame_start,
  input  logic frame_end,
  output logic shot_fire,
  output logic shot_done
);
  logic req_rise;
  logic clr_rise;
  logic armed_q;
  logic grab_q;

  fg_edge #(.RISING(1'b1)) u_req_edge (
    .clk(clk), .rst_n(rst_n), .sig(shot_req), .evt(req_rise)
  );
  fg_edge #(.RISING(1'b1)) u_clr_edge (
    .clk(clk), .rst_n(rst_n), .sig(done_clr), .evt(clr_rise)
  );

  assign shot_fire = frame_start & hold_en & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      grab_q    <= 1'b0;
      shot_done <= 1'b0;
    end else begin
      if (!hold_en)       armed_q <= 1'b0;
      else if (shot_fire) armed_q <= 1'b0;
      else if (req_rise)  armed_q <= 1'b1;

      if (shot_fire)      grab_q <= 1'b1;
      else if (frame_end) grab_q <= 1'b0;

      if (frame_end && grab_q) shot_done <= 1'b1;
      else if (clr_rise)       shot_done <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_gate.sv
module frame_gate #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fv_in,
  input  logic             lv_in,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [7:0]       ratio_code,
  input  logic             hold_en,
  input  logic             shot_req,
  input  logic             done_clr,
  input  logic             mute,
  output logic             fv_out,
  output logic             lv_out,
  output logic [PIX_W-1:0] pix_out,
  output logic             shot_done
);
  // Named internal events, visible to the bound checker.
  logic frame_start;
  logic frame_end;
  logic shot_fire;
  logic sched_keep;
  logic pass_start;
  logic keep_q;
  logic keep_live;
  logic gate_fv;
  logic gate_lv;

  fg_edge #(.RISING(1'b1)) u_fv_rise (
    .clk(clk), .rst_n(rst_n), .sig(fv_in), .evt(frame_start)
  );
  fg_edge #(.RISING(1'b0)) u_fv_fall (
    .clk(clk), .rst_n(rst_n), .sig(fv_in), .evt(frame_end)
  );

  fg_ratio_sched u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_start (frame_start & ~hold_en),
    .ratio_code  (ratio_code),
    .keep_now    (sched_keep)
  );

  fg_shot_ctrl u_shot (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_en     (hold_en),
    .shot_req    (shot_req),
    .done_clr    (done_clr),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .shot_fire   (shot_fire),
    .shot_done   (shot_done)
  );

  assign pass_start = hold_en ? shot_fire : sched_keep;
  assign keep_live  = frame_start ? pass_start : keep_q;
  assign gate_fv    = fv_in & keep_live & ~mute;
  assign gate_lv    = gate_fv & lv_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q  <= 1'b0;
      fv_out  <= 1'b0;
      lv_out  <= 1'b0;
      pix_out <= '0;
    end else begin
      if (frame_start) keep_q <= pass_start;
      fv_out  <= gate_fv;
      lv_out  <= gate_lv;
      pix_out <= gate_lv ? pix_in : '0;
    end
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fv_in,
  input logic             hold_en,
  input logic             done_clr,
  input logic             mute,
  input logic             fv_out,
  input logic             lv_out,
  input logic [PIX_W-1:0] pix_out,
  input logic             shot_done,
  input logic             frame_start,
  input logic             frame_end,
  input logic             shot_fire
);
  // R2: line-valid only inside frame-valid
  a_r2_lv_in_fv: assert property (@(posedge clk) disable iff (!rst_n)
    lv_out |-> fv_out);
  // R2: blank pixels outside lines
  a_r2_pix_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !lv_out |-> (pix_out == '0));
  // R8: a passed frame continues while the input frame continues
  a_r8_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (fv_out && fv_in && !mute) |=> fv_out);
  // R12: mute blanks output next cycle
  a_r12_mute_blank: assert property (@(posedge clk) disable iff (!rst_n)
    mute |=> !fv_out);
  // R9: held frame without a fired capture is dropped
  a_r9_hold_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && hold_en && !shot_fire) |=> !fv_out);
  // R10: a capture only fires in hold mode
  a_r10_fire_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    shot_fire |-> hold_en);
  // R11: completion flag is sticky without a clear
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (shot_done && !done_clr) |=> shot_done);
  // R11: completion flag rises only after a frame end
  a_r11_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shot_done) |-> $past(frame_end));
endmodule

bind frame_gate fg_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fv_in(fv_in), .hold_en(hold_en),
  .done_clr(done_clr), .mute(mute), .fv_out(fv_out), .lv_out(lv_out),
  .pix_out(pix_out), .shot_done(shot_done), .frame_start(frame_start),
  .frame_end(frame_end), .shot_fire(shot_fire)
);

// File: tb/frame_gate_tb.sv
module frame_gate_tb;
  localparam int PIX_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fv_in = 1'b0, lv_in = 1'b0;
  logic [PIX_W-1:0] pix_in = '0;
  logic [7:0]       ratio_code = 8'h00;
  logic             hold_en = 1'b0, shot_req = 1'b0, done_clr = 1'b0, mute = 1'b0;
  logic             fv_out, lv_out, shot_done;
  logic [PIX_W-1:0] pix_out;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model state
  int       cnt = 0;
  bit [7:0] last_code = 8'h00;
  bit       armed = 0;

  always #4 clk = ~clk;

  frame_gate #(.PIX_W(PIX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fv_in(fv_in), .lv_in(lv_in), .pix_in(pix_in),
    .ratio_code(ratio_code), .hold_en(hold_en), .shot_req(shot_req),
    .done_clr(done_clr), .mute(mute), .fv_out(fv_out), .lv_out(lv_out),
    .pix_out(pix_out), .shot_done(shot_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Counter-modulo restatement of the ratio rule.
  function automatic bit model_keep(input bit [7:0] code, input int c);
    int k, w;
    k = int'(code[7:4]);
    w = int'(code[3:0]);
    if (code == 8'h00) return 1;
    if (code == 8'h01) return (c % 2) == 0;
    if (w == 0 || k >= w) return 1;
    return (c % w) < k;
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    cyc(); cyc();
    @(negedge clk); s = 1'b0;
    cyc();
  endtask

  task automatic shot();
    if (hold_en) armed = 1;
    pulse(shot_req);
  endtask

  task automatic set_hold(input bit h);
    @(negedge clk); hold_en = h;
    if (!h) armed = 0;
    cyc();
  endtask

  // Drive one frame and compare every cycle; returns the expected keep.
  task automatic run_frame(input int lines, input int wid, input bit stop,
                           input int mid_code, input string req, output bit exp);
    bit bad = 0;
    int bad_act = 0, bad_exp = 0;
    bit f, l;
    logic [PIX_W-1:0] p;
    int total;
    if (hold_en) begin
      exp = armed;
      armed = 0;
    end else begin
      if (ratio_code != last_code) begin cnt = 0; last_code = ratio_code; end
      exp = model_keep(ratio_code, cnt);
      cnt++;
    end
    total = 1 + lines * (wid + 2) + 3;
    for (int t = 0; t < total; t++) begin
      f = (t < total - 3);
      l = f && (t >= 1) && (((t - 1) % (wid + 2)) < wid);
      p = l ? PIX_W'($urandom) : '0;
      @(negedge clk);
      fv_in = f; lv_in = l; pix_in = p; mute = stop;
      if (mid_code >= 0 && t == total / 2) ratio_code = mid_code[7:0];
      cyc();
      if (fv_out !== (f & exp & !stop) || lv_out !== (l & exp & !stop) ||
          pix_out !== ((l & exp & !stop) ? p : '0)) begin
        if (!bad) begin bad_act = {fv_out, lv_out}; bad_exp = {f & exp & !stop, l & exp & !stop}; end
        bad = 1;
      end
    end
    @(negedge clk); mute = 1'b0;
    chk(!bad, req, $sformatf("frame code=%02h keep=%0d fv/lv", ratio_code, exp),
        bad_act, bad_exp);
  endtask

  task automatic frames(input bit [7:0] code, input int n, input string req);
    bit e;
    @(negedge clk); ratio_code = code;
    for (int i = 0; i < n; i++) run_frame(1 + (i % 2), 3, 0, -1, req, e);
  endtask

  initial begin
    bit e;
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    chk(fv_out === 0 && lv_out === 0 && pix_out === 0 && shot_done === 0,
        "R1", "outputs in reset", int'({fv_out, lv_out, shot_done}), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc();
    chk(fv_out === 0 && shot_done === 0, "R1", "outputs after reset", int'({fv_out, shot_done}), 0);

    frames(8'h00, 3, "R2 R3");
    frames(8'h11, 2, "R3");
    frames(8'h53, 3, "R3");
    frames(8'h40, 2, "R3");
    frames(8'h01, 4, "R4");
    frames(8'h23, 6, "R5");
    frames(8'h34, 8, "R5");
    frames(8'h1F, 16, "R5");
    frames(8'h05, 3, "R6");
    // R7: change mid-window and mid-frame
    frames(8'h13, 2, "R7");
    run_frame(1, 3, 0, 8'h12, "R7 R8", e);
    frames(8'h12, 3, "R7");
    // R9: hold freezes the window
    frames(8'h13, 1, "R9");
    set_hold(1);
    run_frame(2, 3, 0, -1, "R9", e);
    run_frame(1, 3, 0, -1, "R9", e);
    set_hold(0);
    frames(8'h13, 3, "R9");
    // R10: edge ignored outside hold, then armed capture
    shot();
    set_hold(1);
    run_frame(1, 3, 0, -1, "R10", e);
    chk(shot_done === 0, "R10", "done after ignored shot", shot_done, 0);
    shot();
    run_frame(2, 4, 0, -1, "R10", e);
    cyc();
    chk(shot_done === 1, "R11", "done after capture", shot_done, 1);
    run_frame(1, 3, 0, -1, "R10", e);
    chk(shot_done === 1, "R11", "done sticky", shot_done, 1);
    pulse(done_clr);
    chk(shot_done === 0, "R11", "done after clear", shot_done, 0);
    shot();
    set_hold(0);
    set_hold(1);
    run_frame(1, 3, 0, -1, "R10", e);
    chk(shot_done === 0, "R10", "disarmed by hold drop", shot_done, 0);
    set_hold(0);
    // R12: mute keeps counting
    @(negedge clk); ratio_code = 8'h12;
    run_frame(1, 3, 1, -1, "R12", e);
    run_frame(1, 3, 0, -1, "R12", e);
    run_frame(1, 3, 0, -1, "R12", e);
    run_frame(1, 3, 1, -1, "R12", e);
    run_frame(1, 3, 0, -1, "R12", e);
    // random mix
    for (int i = 0; i < 40; i++) begin
      bit [7:0] pick [11] = '{8'h00, 8'h11, 8'h01, 8'h12, 8'h13, 8'h23,
                              8'h34, 8'h1F, 8'h05, 8'h62, 8'h30};
      if ($urandom % 4 == 0) begin
        @(negedge clk); ratio_code = pick[$urandom % 11];
      end
      run_frame(1 + int'($urandom % 3), 1 + int'($urandom % 5),
                ($urandom % 6) == 0, -1, "R5 R12", e);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule